// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block is the device-side command front end of a two-bank synchronous DRAM. On every rising clock edge it samples the active-low command pins (chip select, row strobe, column strobe, write enable), the clock enable, a bank select and an 11-bit address. It turns each accepted pin pattern into one decoded strobe. The strobe carries its payload: the opened row, the accessed column, the bank, the auto-precharge request, or the mode value. The block keeps an open/idle flag and the open row for each bank. It closes banks on precharge and on a pending auto-precharge. It holds the device in self-refresh for as long as the clock enable stays low.

The decoded strobes are one-cycle pulses with no back-pressure. The block has no ready input, and a strobe that downstream logic misses is lost. The pins are command inputs with no valid/ready pairing: a pattern present at an enabled edge is taken at that edge. Commands that break the open/idle rules raise an error strobe instead of their own strobe, and the bank state is left untouched.

Top module: `sdr_cmd_front`

## Requirements
- R1: After reset every strobe is low, every bank is idle and the self-refresh flag is low.
- R2: With cs_n high nothing is decoded, whatever the strobes show. The {ras_n,cas_n,we_n} codes 111 and 110 with cs_n low are no-operations. Neither case raises a strobe or changes any bank.
- R3: Code 011 (activate) to an idle bank raises act_stb, opens bank ba and records addr[10:0] as that bank's open row, reported on cmd_row and open_rows.
- R4: Code 101 (read) or 100 (write) to an open bank raises rd_stb or wr_stb. It reports cmd_bank, cmd_col = addr[7:0] (bits 9:8 dropped) and cmd_ap = addr[10].
- R5: A read or write with addr[10] high closes its bank BURST_LEN enabled edges after the edge that accepted it. A later read or write to the same bank restarts the count, or cancels it when its own addr[10] is low.
- R6: Code 010 (precharge) raises pre_stb. With addr[10] low it closes only bank ba. With addr[10] high it closes every bank, reports pre_all high and ignores ba.
- R7: A read or write to an idle bank, or an activate to an open bank, raises err_stb alone and leaves every bank flag and row unchanged.
- R8: A command is taken only at an edge whose preceding edge sampled cke high. The edge after a low cke sample decodes nothing and freezes the auto-precharge counts. The first edge after reset decodes nothing.
- R9: Code 001 (refresh) with cke high raises aref_stb. With cke low it sets self_ref and raises no strobe. self_ref stays set while cke is low. The first edge sampling cke high clears it, and that edge decodes nothing.
- R10: Code 000 (mode set) raises mrs_stb and reports the full address on mode_val.
- R11: Strobes and payloads are registered: they appear after the edge that sampled the command, never before it, and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address; top bit is the precharge option |
| act_stb | output | 1 | Activate accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| pre_stb | output | 1 | Precharge accepted |
| aref_stb | output | 1 | Auto refresh accepted |
| mrs_stb | output | 1 | Mode set accepted |
| err_stb | output | 1 | Illegal command for the bank state |
| cmd_bank | output | BA_W | Bank of the last command |
| cmd_row | output | ADDR_W | Row of the last activate |
| cmd_col | output | COL_W | Column of the last read or write |
| cmd_ap | output | 1 | Auto-precharge request of the last read or write |
| pre_all | output | 1 | Last precharge closed all banks |
| mode_val | output | ADDR_W | Value of the last mode set |
| bank_open | output | NBANK | Per-bank open flag |
| open_rows | output | NBANK*ADDR_W | Open row of each bank, bank 0 lowest |
| self_ref | output | 1 | Self-refresh in progress |

## Verification
A wrong bank flag or row shows up at the ports on the very next cycle, because bank_open and open_rows come straight from the bank state. It also changes how later commands are judged: a stale open flag turns a legal read into err_stb, or lets an illegal activate through. A miscounted auto-precharge shows as bank_open falling one or more enabled edges early or late. A lost cke history shows as a strobe on an edge that should be quiet. The bench runs a behavioural model beside the design and compares every output on every clock, so each such fault is reported in the cycle it first appears.

// File: rtl/sdr_front_pkg.sv
package sdr_front_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_pin_decode.sv
module sdr_pin_decode
  import sdr_front_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdr_cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_clk_gate.sv
module sdr_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic ref_taken,
  output logic cke_q,
  output logic self_ref,
  output logic tick
);
  assign tick = cke_q & ~self_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      self_ref <= 1'b0;
    end else begin
      cke_q <= cke;
      if (self_ref) begin
        if (cke) self_ref <= 1'b0;
      end else if (ref_taken && !cke) begin
        self_ref <= 1'b1;
      end
    end
  end

  AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && !cke) |=> self_ref); // R9
  AST_SREF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && cke) |=> !self_ref); // R9
endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int ROW_W     = 11,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             do_act,
  input  logic             do_close,
  input  logic             do_rw,
  input  logic             rw_ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  logic             pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
      pend   <= 1'b0;
      cnt    <= '0;
    end else if (tick) begin
      if (do_act) begin
        active <= 1'b1;
        row    <= row_in;
        pend   <= 1'b0;
      end else if (do_close) begin
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (do_rw) begin
        pend <= rw_ap;
        cnt  <= CNT_LOAD;
      end else if (pend) begin
        if (cnt == '0) begin
          active <= 1'b0;
          pend   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_PEND_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> active); // R5
  AST_FROZEN_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(active) && $stable(row))); // R8
endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
  import sdr_front_pkg::*;
#(
  parameter int NBANK     = 2,
  parameter int ADDR_W    = 11,
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    act_stb,
  output logic                    rd_stb,
  output logic                    wr_stb,
  output logic                    pre_stb,
  output logic                    aref_stb,
  output logic                    mrs_stb,
  output logic                    err_stb,
  output logic [BA_W-1:0]         cmd_bank,
  output logic [ADDR_W-1:0]       cmd_row,
  output logic [COL_W-1:0]        cmd_col,
  output logic                    cmd_ap,
  output logic                    pre_all,
  output logic [ADDR_W-1:0]       mode_val,
  output logic [NBANK-1:0]        bank_open,
  output logic [NBANK*ADDR_W-1:0] open_rows,
  output logic                    self_ref
);
  localparam int AP_BIT = ADDR_W - 1;

  sdr_cmd_e cmd;
  logic     tick, cke_q, ref_taken;
  logic     cur_open, is_rw, go_act, go_rw, go_err;

  sdr_pin_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  assign ref_taken = tick && (cmd == CMD_REF);

  sdr_clk_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .ref_taken(ref_taken),
    .cke_q    (cke_q),
    .self_ref (self_ref),
    .tick     (tick)
  );

  always_comb begin
    cur_open = bank_open[ba];
    is_rw    = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    go_act   = tick && (cmd == CMD_ACT) && !cur_open;
    go_rw    = tick && is_rw && cur_open;
    go_err   = tick && (((cmd == CMD_ACT) && cur_open) || (is_rw && !cur_open));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(b));
    sdr_bank_slot #(
      .ROW_W    (ADDR_W),
      .BURST_LEN(BURST_LEN)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .do_act  (go_act && sel),
      .do_close((cmd == CMD_PRE) && (addr[AP_BIT] || sel)),
      .do_rw   (go_rw && sel),
      .rw_ap   (addr[AP_BIT]),
      .row_in  (addr),
      .active  (bank_open[b]),
      .row     (open_rows[b*ADDR_W +: ADDR_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_stb  <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      pre_stb  <= 1'b0;
      aref_stb <= 1'b0;
      mrs_stb  <= 1'b0;
      err_stb  <= 1'b0;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      pre_all  <= 1'b0;
      mode_val <= '0;
    end else begin
      act_stb  <= go_act;
      rd_stb   <= go_rw && (cmd == CMD_READ);
      wr_stb   <= go_rw && (cmd == CMD_WRITE);
      pre_stb  <= tick && (cmd == CMD_PRE);
      aref_stb <= ref_taken && cke;
      mrs_stb  <= tick && (cmd == CMD_MRS);
      err_stb  <= go_err;
      if (tick && (cmd != CMD_NOP)) cmd_bank <= ba;
      if (go_act) cmd_row <= addr;
      if (go_rw) begin
        cmd_col <= addr[COL_W-1:0];
        cmd_ap  <= addr[AP_BIT];
      end
      if (tick && (cmd == CMD_PRE)) pre_all <= addr[AP_BIT];
      if (tick && (cmd == CMD_MRS)) mode_val <= addr;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_stb, rd_stb, wr_stb, pre_stb, aref_stb, mrs_stb, err_stb})); // R7
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_stb |-> (bank_open[cmd_bank] && (open_rows[cmd_bank*ADDR_W +: ADDR_W] == cmd_row))); // R3
  AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> bank_open[cmd_bank]); // R4
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_stb && pre_all) |-> (bank_open == '0)); // R6
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> !(act_stb || rd_stb || wr_stb || pre_stb || aref_stb || mrs_stb || err_stb)); // R8
  AST_SREF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_ref) |-> !aref_stb); // R9
endmodule

// File: tb/sdr_cmd_front_test.sv
`timescale 1ns/1ps
module sdr_cmd_front_test;
  localparam int NB = 2;
  localparam int AW = 11;
  localparam int CW = 8;
  localparam int BL = 4;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000,
                         K_NOP = 3'b111, K_BST = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic act_stb, rd_stb, wr_stb, pre_stb, aref_stb, mrs_stb, err_stb;
  logic [0:0] cmd_bank;
  logic [AW-1:0] cmd_row, mode_val;
  logic [CW-1:0] cmd_col;
  logic cmd_ap, pre_all, self_ref;
  logic [NB-1:0] bank_open;
  logic [NB*AW-1:0] open_rows;

  always #5 clk = ~clk;

  sdr_cmd_front #(.NBANK(NB), .ADDR_W(AW), .COL_W(CW), .BURST_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
    .aref_stb(aref_stb), .mrs_stb(mrs_stb), .err_stb(err_stb),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .pre_all(pre_all), .mode_val(mode_val), .bank_open(bank_open),
    .open_rows(open_rows), .self_ref(self_ref)
  );

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit m_ckeq, m_sref;
  bit m_open [NB];
  int m_row [NB];
  bit m_pend [NB];
  int m_cnt [NB];
  bit e_act, e_rd, e_wr, e_pre, e_aref, e_mrs, e_err, e_pall, e_ap;
  int e_bank, e_row, e_col, e_mode;

  always @(posedge clk) begin
    bit acc, enter, prev_open;
    bit touched [NB];
    e_act = 0; e_rd = 0; e_wr = 0; e_pre = 0; e_aref = 0; e_mrs = 0; e_err = 0;
    enter = 0;
    if (!rst_n) begin
      m_ckeq = 0; m_sref = 0;
      for (int b = 0; b < NB; b++) begin
        m_open[b] = 0; m_row[b] = 0; m_pend[b] = 0; m_cnt[b] = 0;
      end
    end else begin
      acc = m_ckeq && !m_sref;
      if (acc) begin
        for (int b = 0; b < NB; b++) touched[b] = 0;
        prev_open = m_open[ba];
        if (!cs_n) begin
          case ({ras_n, cas_n, we_n})
            K_ACT: if (prev_open) e_err = 1;
                   else begin
                     e_act = 1; e_bank = ba; e_row = addr;
                     m_open[ba] = 1; m_row[ba] = addr; m_pend[ba] = 0; touched[ba] = 1;
                   end
            K_RD, K_WR: if (!prev_open) e_err = 1;
                   else begin
                     if (we_n) e_rd = 1; else e_wr = 1;
                     e_bank = ba; e_col = addr[7:0]; e_ap = addr[10];
                     m_pend[ba] = addr[10]; m_cnt[ba] = BL; touched[ba] = 1;
                   end
            K_PRE: begin
                     e_pre = 1; e_pall = addr[10]; e_bank = ba;
                     for (int b = 0; b < NB; b++)
                       if (addr[10] || b == ba) begin
                         m_open[b] = 0; m_pend[b] = 0; touched[b] = 1;
                       end
                   end
            K_REF: if (cke) e_aref = 1; else enter = 1;
            K_MRS: begin e_mrs = 1; e_mode = addr; end
            default: ;
          endcase
        end
        for (int b = 0; b < NB; b++)
          if (!touched[b] && m_pend[b]) begin
            m_cnt[b]--;
            if (m_cnt[b] == 0) begin m_open[b] = 0; m_pend[b] = 0; end
          end
      end
      if (m_sref) begin
        if (cke) m_sref = 0;
      end else if (enter) m_sref = 1;
      m_ckeq = cke;
    end
  end

  task automatic compare();
    logic [6:0] es, as;
    logic [63:0] ep, ap;
    logic [NB-1:0] eo;
    logic [NB*AW-1:0] er, ar;
    es = {e_act, e_rd, e_wr, e_pre, e_aref, e_mrs, e_err};
    as = {act_stb, rd_stb, wr_stb, pre_stb, aref_stb, mrs_stb, err_stb};
    ep = '0; ap = '0;
    if (e_act) begin ep = {32'(e_bank), 32'(e_row)}; ap = {32'(cmd_bank), 32'(cmd_row)}; end
    if (e_rd || e_wr) begin
      ep = {32'(e_bank), 31'(e_col), e_ap}; ap = {32'(cmd_bank), 31'(cmd_col), cmd_ap};
    end
    if (e_pre) begin
      ep = {32'(e_pall ? 0 : e_bank), 32'(e_pall)};
      ap = {32'(pre_all ? 1'b0 : cmd_bank), 32'(pre_all)};
    end
    if (e_mrs) begin ep = 64'(e_mode); ap = 64'(mode_val); end
    for (int b = 0; b < NB; b++) begin
      eo[b] = m_open[b];
      er[b*AW +: AW] = m_open[b] ? AW'(m_row[b]) : '0;
      ar[b*AW +: AW] = m_open[b] ? open_rows[b*AW +: AW] : '0;
    end
    vectors++;
    if (as !== es || ap !== ap || ap !== ep || bank_open !== eo || ar !== er || self_ref !== m_sref) begin
      miscompares++;
      $display("FAIL %s: got stb=%b pay=%h open=%b rows=%h sref=%b, want stb=%b pay=%h open=%b rows=%h sref=%b",
               cur_req, as, ap, bank_open, ar, self_ref, es, ep, eo, er, m_sref);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    vectors++;
    if (got !== want) begin
      miscompares++;
      $display("FAIL %s: got %h want %h", req, got, want);
    end
  endtask

  task automatic step(input logic c_ke, input logic c_cs, input logic [2:0] code,
                      input logic b, input logic [AW-1:0] a);
    cke = c_ke; cs_n = c_cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic op(input logic [2:0] code, input logic b, input logic [AW-1:0] a);
    step(1'b1, 1'b0, code, b, a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(K_NOP, 1'b0, '0);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout want completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", {act_stb, rd_stb, wr_stb, pre_stb, aref_stb, mrs_stb, err_stb}, 0);
    chk("R1", bank_open, 0);
    chk("R1", self_ref, 0);
    rst_n = 1'b1;
    cur_req = "R8";              // first edge after reset decodes nothing
    op(K_ACT, 1'b0, 11'h123);
    chk("R8", bank_open, 0);
    cur_req = "R11";
    cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = K_ACT; ba = 1'b0; addr = 11'h5A3;
    #1 chk("R11", act_stb, 0);
    @(posedge clk); @(negedge clk);
    compare();
    chk("R11", act_stb, 1);
    cur_req = "R3";
    op(K_ACT, 1'b1, 11'h7FF);
    chk("R3", open_rows[AW +: AW], 11'h7FF);
    cur_req = "R7";
    op(K_ACT, 1'b0, 11'h001);
    chk("R7", open_rows[0 +: AW], 11'h5A3);
    cur_req = "R4";
    op(K_RD, 1'b0, 11'h0C4);
    op(K_WR, 1'b1, 11'h3FF);
    chk("R4", cmd_col, 8'hFF);
    cur_req = "R2";
    step(1'b1, 1'b1, K_ACT, 1'b0, 11'h0AA);
    step(1'b1, 1'b1, K_PRE, 1'b0, 11'h400);
    op(K_BST, 1'b1, 11'h000);
    op(K_NOP, 1'b0, 11'h400);
    chk("R2", bank_open, 2'b11);
    cur_req = "R6";
    op(K_PRE, 1'b1, 11'h000);
    chk("R6", bank_open, 2'b01);
    cur_req = "R7";
    op(K_RD, 1'b1, 11'h010);
    op(K_WR, 1'b1, 11'h010);
    cur_req = "R5";
    op(K_RD, 1'b0, 11'h411);
    idle(2);
    chk("R5", bank_open[0], 1);
    idle(3);
    chk("R5", bank_open[0], 0);
    op(K_ACT, 1'b0, 11'h222);
    op(K_WR, 1'b0, 11'h433);
    idle(2);
    op(K_WR, 1'b0, 11'h433);      // restart
    idle(2);
    op(K_WR, 1'b0, 11'h034);      // cancel
    idle(6);
    chk("R5", bank_open[0], 1);
    cur_req = "R8";
    step(1'b0, 1'b0, K_ACT, 1'b1, 11'h155);   // taken, next edge gated
    op(K_RD, 1'b1, 11'h001);                  // ignored
    op(K_WR, 1'b0, 11'h4FE);
    step(1'b0, 1'b0, K_NOP, 1'b0, '0);
    step(1'b0, 1'b0, K_NOP, 1'b0, '0);
    step(1'b0, 1'b0, K_NOP, 1'b0, '0);
    idle(5);
    cur_req = "R6";
    op(K_ACT, 1'b0, 11'h0F0);
    op(K_PRE, 1'b0, 11'h400);
    chk("R6", bank_open, 2'b00);
    chk("R6", pre_all, 1);
    cur_req = "R9";
    op(K_REF, 1'b0, 11'h000);
    chk("R9", aref_stb, 1);
    step(1'b0, 1'b0, K_REF, 1'b0, 11'h000);
    chk("R9", self_ref, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, K_ACT, 1'b0, 11'h0AB);
    op(K_ACT, 1'b0, 11'h0AB);
    chk("R9", self_ref, 0);
    chk("R9", bank_open, 2'b00);
    op(K_ACT, 1'b0, 11'h0AB);
    cur_req = "R10";
    op(K_MRS, 1'b0, 11'h233);
    chk("R10", mode_val, 11'h233);
    idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule